// File: doc/BRIEF.md
# Battery pre-charge pulse controller

This block revives a deeply discharged battery while the host processor is still powered down. When a charger is attached, the host is off and the battery sits below its low-voltage threshold, the block drives the enable of an external charge pass transistor on its own. It uses a low duty pulse pattern timed from a 1 ms tick: on for a short window at the start of every period. A charging indicator LED flashes in step with the pulses so the user can see that charging is under way.

Once the battery crosses its upper pre-charge threshold, the block stops pulsing. It also stops once the host has booted and raised its charge command. From then on the pass-transistor enable and the LED simply follow the host's charge and LED commands, and fast charge and end-of-charge pulsing are both driven through that same single enable. Pulling the charger out at any moment drops both outputs and sends the block back to idle. The host commands are honoured only while the host reports itself powered, which stands in for the pull-downs on those lines when the host is off.

Top module: `precharge_ctrl`

## Requirements
- R1: While rst_ni is low, gate_en_o and led_o are 0 and the block is idle.
- R2: From idle, when chg_present_i=1, host_on_i=0 and bat_low_i=1 at a clock edge, pre-charge starts; after that edge gate_en_o=1, which is the first cycle of a fresh period.
- R3: During pre-charge, gate_en_o is 1 for the first ON_TICKS ticks of each period and 0 for the remaining PERIOD_TICKS-ON_TICKS ticks. The phase advances only on edges where tick_i=1.
- R4: During pre-charge, led_o equals gate_en_o, whatever the value of host_led_i.
- R5: When bat_high_i=1 during pre-charge, the block returns to idle at the next edge, and both outputs stay 0 while the battery is not low and the host is off.
- R6: When host_on_i=1 and host_chg_i=1 during pre-charge, the block hands over to host control at the next edge.
- R7: Under host control with host_on_i=1, gate_en_o follows host_chg_i and led_o follows host_led_i in the same cycle.
- R8: Outside pre-charge, when host_on_i=0, host_chg_i and host_led_i have no effect and both outputs are 0.
- R9: When chg_present_i=0, both outputs are 0 at once and the block is idle after the next edge. A later pre-charge restarts its period from the beginning.
- R10: From idle with a charger present and host_on_i=1, the block enters host control and does not pre-charge, even when bat_low_i=1.
- R11: During pre-charge with host_on_i=1 and host_chg_i=0, pulsing continues unchanged.
- R12: From idle with a charger present, host_on_i=0 and bat_low_i=0, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, once per millisecond |
| chg_present_i | input | 1 | External charger attached |
| bat_low_i | input | 1 | Battery below the pre-charge start threshold |
| bat_high_i | input | 1 | Battery above the pre-charge stop threshold |
| host_on_i | input | 1 | Host processor powered |
| host_chg_i | input | 1 | Host charge command |
| host_led_i | input | 1 | Host LED command |
| gate_en_o | output | 1 | Pass-transistor enable |
| led_o | output | 1 | Charging indicator LED drive |

## Verification
The properties assume that the two battery flags are never high together, since they come from comparators with separated thresholds. They also assume that all inputs are synchronous to clk_i and that tick_i is a single-cycle strobe. The bench changes every input only on the falling edge, and it never raises bat_low_i and bat_high_i in the same cycle. Ticks are applied on alternate cycles so that the phase is seen to hold between them. The pulse timing is checked with short terminal counts, which keep whole periods within a few dozen cycles.

// File: rtl/precharge_pkg.sv
package precharge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_HOST = 2'd2
  } pc_state_e;
endpackage

// File: rtl/precharge_phase.sv
module precharge_phase #(
  parameter int unsigned ON_TICKS     = 100,
  parameter int unsigned PERIOD_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic pulse_on_o
);
  localparam int unsigned CW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] ON_LIM = CW'(ON_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign pulse_on_o = (cnt_q < ON_LIM);
endmodule

// File: rtl/precharge_fsm.sv
module precharge_fsm
  import precharge_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      chg_present_i,
  input  logic      bat_low_i,
  input  logic      bat_high_i,
  input  logic      host_on_i,
  input  logic      host_chg_i,
  output pc_state_e st_o
);
  pc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (chg_present_i && host_on_i)      st_d = ST_HOST;
        else if (chg_present_i && bat_low_i) st_d = ST_PRE;
      end
      ST_PRE: begin
        if (!chg_present_i || bat_high_i)    st_d = ST_IDLE;
        else if (host_on_i && host_chg_i)    st_d = ST_HOST;
      end
      ST_HOST: begin
        if (!chg_present_i || !host_on_i)    st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/precharge_outmux.sv
module precharge_outmux
  import precharge_pkg::*;
(
  input  pc_state_e st_i,
  input  logic      pulse_on_i,
  input  logic      chg_present_i,
  input  logic      host_on_i,
  input  logic      host_chg_i,
  input  logic      host_led_i,
  output logic      gate_en_o,
  output logic      led_o
);
  logic in_pre, host_ok;

  assign in_pre  = (st_i == ST_PRE);
  // host lines read as pulled low while the host is unpowered
  assign host_ok = (st_i == ST_HOST) && host_on_i;

  always_comb begin
    gate_en_o = 1'b0;
    led_o     = 1'b0;
    if (chg_present_i) begin
      if (in_pre) begin
        gate_en_o = pulse_on_i;
        led_o     = pulse_on_i;
      end else if (host_ok) begin
        gate_en_o = host_chg_i;
        led_o     = host_led_i;
      end
    end
  end
endmodule

// File: rtl/precharge_ctrl.sv
module precharge_ctrl
  import precharge_pkg::*;
#(
  parameter int unsigned ON_TICKS     = 100,
  parameter int unsigned PERIOD_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic chg_present_i,
  input  logic bat_low_i,
  input  logic bat_high_i,
  input  logic host_on_i,
  input  logic host_chg_i,
  input  logic host_led_i,
  output logic gate_en_o,
  output logic led_o
);
  pc_state_e st;
  logic      pulse_on;

  precharge_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chg_present_i (chg_present_i),
    .bat_low_i     (bat_low_i),
    .bat_high_i    (bat_high_i),
    .host_on_i     (host_on_i),
    .host_chg_i    (host_chg_i),
    .st_o          (st)
  );

  precharge_phase #(
    .ON_TICKS     (ON_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (st != ST_PRE),
    .tick_i     (tick_i),
    .pulse_on_o (pulse_on)
  );

  precharge_outmux i_outmux (
    .st_i          (st),
    .pulse_on_i    (pulse_on),
    .chg_present_i (chg_present_i),
    .host_on_i     (host_on_i),
    .host_chg_i    (host_chg_i),
    .host_led_i    (host_led_i),
    .gate_en_o     (gate_en_o),
    .led_o         (led_o)
  );
endmodule

// File: rtl/precharge_ctrl_chk.sv
module precharge_ctrl_chk
  import precharge_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      chg_present_i,
  input logic      bat_low_i,
  input logic      bat_high_i,
  input logic      host_on_i,
  input logic      host_chg_i,
  input logic      host_led_i,
  input logic      gate_en_o,
  input logic      led_o,
  input pc_state_e st_i
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!gate_en_o && !led_o);
    end
  end

  a_r2_start_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && chg_present_i && !host_on_i && bat_low_i)
    |=> (!chg_present_i || gate_en_o));

  a_r4_led_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PRE) |-> (led_o == gate_en_o));

  a_r5_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PRE && bat_high_i) |=> (st_i == ST_IDLE));

  a_r6_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PRE && chg_present_i && !bat_high_i && host_on_i && host_chg_i)
    |=> (st_i == ST_HOST));

  a_r7_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_HOST && chg_present_i && host_on_i)
    |-> (gate_en_o == host_chg_i && led_o == host_led_i));

  a_r8_host_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_on_i && st_i != ST_PRE) |-> (!gate_en_o && !led_o));

  a_r9_unplug_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_present_i |=> (st_i == ST_IDLE));

  a_r10_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && chg_present_i && host_on_i) |=> (st_i == ST_HOST));

  a_r12_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE && !host_on_i && !bat_low_i) |=> (st_i == ST_IDLE));
endmodule

bind precharge_ctrl precharge_ctrl_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chg_present_i (chg_present_i),
  .bat_low_i     (bat_low_i),
  .bat_high_i    (bat_high_i),
  .host_on_i     (host_on_i),
  .host_chg_i    (host_chg_i),
  .host_led_i    (host_led_i),
  .gate_en_o     (gate_en_o),
  .led_o         (led_o),
  .st_i          (st)
);

// File: tb/test_precharge_ctrl.sv
`timescale 1ns/1ps
module test_precharge_ctrl;
  localparam int ON  = 3;
  localparam int PER = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tk = 1'b0, chg = 1'b0, blo = 1'b0, bhi = 1'b0;
  logic hon = 1'b0, hchg = 1'b0, hled = 1'b0;
  logic n_rst = 1'b0, n_chg = 1'b0, n_blo = 1'b0, n_bhi = 1'b0;
  logic n_hon = 1'b0, n_hchg = 1'b0, n_hled = 1'b0;
  logic gate, led;

  always #5 clk = ~clk;

  precharge_ctrl #(.ON_TICKS(ON), .PERIOD_TICKS(PER)) i_precharge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tk), .chg_present_i(chg),
    .bat_low_i(blo), .bat_high_i(bhi), .host_on_i(hon),
    .host_chg_i(hchg), .host_led_i(hled), .gate_en_o(gate), .led_o(led)
  );

  typedef struct {
    logic  g;
    logic  l;
    string rid;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  int n = 0;
  bit done = 1'b0;

  // driver: apply staged inputs on the falling edge, queue expectation after the rising edge
  task automatic cyc(input logic t, input logic eg, input logic el, input string rid);
    @(negedge clk);
    rst_n = n_rst; chg = n_chg; blo = n_blo; bhi = n_bhi;
    hon = n_hon; hchg = n_hchg; hled = n_hled; tk = t;
    @(posedge clk);
    q.push_back('{g: eg, l: el, rid: rid});
  endtask

  task automatic run_pulses(input int cycles, input string rid);
    for (int i = 0; i < cycles; i++) begin
      logic t;
      logic on;
      t = (i % 2 == 1);
      if (t) n++;
      on = ((n % PER) < ON);
      cyc(t, on, on, rid);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (gate !== e.g || led !== e.l) begin
          failures++;
          $display("FAIL %s: gate=%b led=%b expected gate=%b led=%b at %0t",
                   e.rid, gate, led, e.g, e.l, $time);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: held in reset with pre-charge conditions present
    n_chg = 1; n_blo = 1;
    cyc(1, 0, 0, "R1");
    cyc(1, 0, 0, "R1");
    // R9: release reset with charger absent
    n_rst = 1; n_chg = 0;
    cyc(0, 0, 0, "R9");
    // R12 and R8: charger present, battery fine, host off, host commands high
    n_chg = 1; n_blo = 0; n_hchg = 1; n_hled = 1;
    cyc(1, 0, 0, "R12");
    cyc(0, 0, 0, "R8");
    cyc(1, 0, 0, "R8");
    // R2: start, then R3/R4 pulse pattern with LED in step
    n_blo = 1;
    cyc(0, 1, 1, "R2");
    n = 0;
    run_pulses(26, "R3/R4");
    // R11: host powered, no charge command yet
    n_hon = 1; n_hchg = 0;
    run_pulses(6, "R11");
    // R6: handover, R7: follow host
    n_hchg = 1; n_hled = 0;
    cyc(0, 1, 0, "R6");
    n_hchg = 0; n_hled = 1;
    cyc(1, 0, 1, "R7");
    n_hchg = 1; n_hled = 0;
    cyc(0, 1, 0, "R7");
    // R9: unplug under host control
    n_chg = 0;
    cyc(0, 0, 0, "R9");
    n_chg = 1; n_hon = 0; n_blo = 0; n_hchg = 1; n_hled = 1;
    cyc(1, 0, 0, "R8");
    // R5: stop on high battery
    n_blo = 1;
    cyc(0, 1, 1, "R2");
    n = 0;
    run_pulses(4, "R3");
    n_blo = 0; n_bhi = 1;
    cyc(0, 0, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(i[0], 0, 0, "R5");
    // R9: unplug in off phase, replug restarts the period
    n_bhi = 0; n_blo = 1;
    cyc(0, 1, 1, "R2");
    n = 0;
    run_pulses(8, "R3");
    n_chg = 0;
    cyc(0, 0, 0, "R9");
    n_chg = 1;
    cyc(0, 1, 1, "R9");
    // R10: host already on when charger appears
    n_chg = 0;
    cyc(0, 0, 0, "R9");
    n_chg = 1; n_hon = 1; n_hchg = 0; n_hled = 0; n_blo = 1;
    cyc(1, 0, 0, "R10");
    cyc(0, 0, 0, "R10");
    cyc(1, 0, 0, "R10");
    n_hchg = 1;
    cyc(0, 1, 0, "R10");
    cyc(0, 1, 0, "R7");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule